// File: doc/BRIEF.md
# Fast-to-Slow Clock Phase Training Controller

This controller aligns the rising edges of a high-speed I/O clock with a slower system clock so that gearing registers can move data between the two domains safely. Unequal insertion delays through the clock routing can leave the two edges misaligned. The controller corrects this by moving only the VCO phase of the PLL output that feeds the high-speed clock. The system clock is never adjusted. Each phase move goes through a request/acknowledge handshake with the PLL. The controller judges each candidate phase by the pass/fail verdict of an eye monitor on a spare lane that carries no live data.

The controller runs on the system clock. A start pulse latches the gearing ratio and a data-rate qualifier. Training runs for ratios 2, 3.5 and 4 at data rates of 400 Mbps or more. In every other case it reports done at once and moves no phase. In a training run it sweeps every phase position upward and keeps the longest contiguous run of passing positions. It then steps back down to the centre of that run.

The high-speed domain sends a toggle, and a watchdog uses it to detect an interrupted clock. Done and error stay set until the next start. The fractional ratio never reports an error.

Top module: `ptrain_ctrl`

## Requirements
- R1: After reset, `done`, `error` and `step_req` are all low.
- R2: A start with `ratio_sel` = 3 (ratio 5) sets `done` with no phase step requested and `error` low. Ratio codes are 0 = x2, 1 = x3.5, 2 = x4 and 3 = x5.
- R3: A start with `rate_ok` low bypasses training in the same way as R2, for any ratio.
- R4: For ratio codes 0, 1 and 2 with `rate_ok` high, the controller issues exactly N_POS upward steps (`step_dir` = 1). Each `step_req` lasts one cycle. After each acknowledge the controller waits `settle_cycles`+1 cycles and then samples `eye_pass`.
- R5: After the sweep, the controller picks the longest contiguous run of passing positions, and the lowest-indexed run wins a tie. It issues downward steps (`step_dir` = 0) until the net offset from the start of training is c+1, where c = run start + (run length − 1)/2 (integer division), and then raises `done`. If c is the last position, it issues no downward step.
- R6: `done` and `error` hold until the next start. A start that begins training clears both by the following cycle.
- R7: When no position passes and the ratio code is 0 or 2, the controller sets `error` and leaves `done` low.
- R8: In ratio code 1 (fractional), `error` is never raised. A sweep with no passing position, or a clock interruption, leaves both `done` and `error` low and stops all stepping.
- R9: While training runs, if `io_clk_tgl` shows no edge for `wdog_limit` system cycles, the controller aborts and sets `error` (non-fractional ratios).
- R10: `done` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Gearing ratio code, latched at start |
| rate_ok | input | 1 | High when the data rate is at least 400 Mbps |
| start | input | 1 | One-cycle pulse that begins training |
| settle_cycles | input | SETTLE_W | Extra wait after each PLL acknowledge |
| wdog_limit | input | WDOG_W | Cycles without an I/O clock toggle before abort |
| io_clk_tgl | input | 1 | Toggle driven from the high-speed domain |
| step_ack | input | 1 | PLL acknowledge of a phase step |
| eye_pass | input | 1 | Eye monitor verdict of the spare lane |
| step_req | output | 1 | One-cycle phase step request |
| step_dir | output | 1 | Step direction, 1 = later phase, 0 = earlier |
| done | output | 1 | Training complete, sticky |
| error | output | 1 | Training failed, sticky |

## Verification
Most internal errors show up at the ports only when training ends. If the run tracker holds a wrong length or start, the count of downward steps is wrong, and the PLL model's net offset shows it when `done` rises, a few hundred cycles after start. A stuck sequencer state shows up within a few cycles as a missing or repeated `step_req`. A wrong watchdog count shows up within about `wdog_limit` cycles as a spurious abort or a missing one. The directed patterns cover a single window, competing windows, equal windows, a pass only at the last position and no pass at all, so that each offset error leaves a distinct final position.

// File: rtl/ptrain_pkg.sv
package ptrain_pkg;
  typedef enum logic [1:0] {
    RATIO_X2   = 2'd0,
    RATIO_X3P5 = 2'd1,
    RATIO_X4   = 2'd2,
    RATIO_X5   = 2'd3
  } ratio_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_SETTLE,
    ST_EVAL,
    ST_PICK
  } state_e;
endpackage

// File: rtl/ptrain_wdog.sv
module ptrain_wdog #(
  parameter int WDOG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tgl_in,
  input  logic [WDOG_W-1:0] limit,
  output logic              expired
);
  logic [2:0]        sync_q;
  logic              tgl_edge;
  logic [WDOG_W-1:0] cnt_q, cnt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tgl_in};
  end

  assign tgl_edge = sync_q[2] ^ sync_q[1];

  always_comb begin
    cnt_n = cnt_q;
    if (!run || tgl_edge)  cnt_n = '0;
    else if (cnt_q != limit) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = run && (cnt_q == limit);

  // R9: once expired, silence keeps it expired
  p_wdog_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && run && !tgl_edge && $stable(limit)) |=> (expired || !run));
  // R9: an edge always restarts the count
  p_wdog_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tgl_edge) |=> (cnt_q == '0));
endmodule

// File: rtl/ptrain_run_track.sv
module ptrain_run_track #(
  parameter int N_POS = 32,
  localparam int IDX_W = $clog2(N_POS),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_en,
  input  logic             pass,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] best_start,
  output logic [LEN_W-1:0] best_len
);
  logic [IDX_W-1:0] cur_start_q, cur_start_n;
  logic [LEN_W-1:0] cur_len_q, cur_len_n;
  logic [IDX_W-1:0] best_start_q;
  logic [LEN_W-1:0] best_len_q;

  always_comb begin
    cur_len_n   = pass ? cur_len_q + 1'b1 : '0;
    cur_start_n = (pass && cur_len_q == '0) ? idx : cur_start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (clear) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (sample_en) begin
      cur_start_q <= cur_start_n;
      cur_len_q   <= cur_len_n;
      if (cur_len_n > best_len_q) begin
        best_start_q <= cur_start_n;
        best_len_q   <= cur_len_n;
      end
    end
  end

  assign best_start = best_start_q;
  assign best_len   = best_len_q;

  // R5: the kept run is never shorter than the run in progress
  p_best_ge_cur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    best_len_q >= cur_len_q);
  // R5: the best run never grows by more than one per sample
  p_best_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (best_len_q <= $past(best_len_q) + 1'b1));
endmodule

// File: rtl/ptrain_ctrl.sv
module ptrain_ctrl
  import ptrain_pkg::*;
#(
  parameter int N_POS    = 32,
  parameter int SETTLE_W = 8,
  parameter int WDOG_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ratio_sel,
  input  logic                rate_ok,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [WDOG_W-1:0]   wdog_limit,
  input  logic                io_clk_tgl,
  input  logic                step_ack,
  input  logic                eye_pass,
  output logic                step_req,
  output logic                step_dir,
  output logic                done,
  output logic                error
);
  localparam int IDX_W = $clog2(N_POS);
  localparam int LEN_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_POS - 1);
  localparam logic [LEN_W-1:0] LAST_W   = LEN_W'(N_POS - 1);

  logic [1:0]          rst_sync_q;
  logic                rst_i_n;
  state_e              state_q, state_n;
  ratio_e              ratio_q, ratio_n;
  logic                back_q, back_n;
  logic [IDX_W-1:0]    idx_q, idx_n;
  logic [IDX_W-1:0]    bcnt_q, bcnt_n;
  logic [SETTLE_W-1:0] scnt_q, scnt_n;
  logic                done_q, done_n, err_q, err_n;
  logic                trk_clear, trk_sample, wdog_run, wdog_exp;
  logic [IDX_W-1:0]    best_start;
  logic [LEN_W-1:0]    best_len, half_len, centre, back_steps;
  logic                bypass;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ptrain_wdog #(.WDOG_W(WDOG_W)) i_wdog (
    .clk(clk), .rst_n(rst_i_n), .run(wdog_run), .tgl_in(io_clk_tgl),
    .limit(wdog_limit), .expired(wdog_exp)
  );

  ptrain_run_track #(.N_POS(N_POS)) i_track (
    .clk(clk), .rst_n(rst_i_n), .clear(trk_clear), .sample_en(trk_sample),
    .pass(eye_pass), .idx(idx_q), .best_start(best_start), .best_len(best_len)
  );

  assign half_len   = (best_len - 1'b1) >> 1;
  assign centre     = {1'b0, best_start} + half_len;
  assign back_steps = LAST_W - centre;
  assign bypass     = (ratio_e'(ratio_sel) == RATIO_X5) || !rate_ok;
  assign wdog_run   = (state_q != ST_IDLE);

  always_comb begin
    state_n    = state_q;
    ratio_n    = ratio_q;
    back_n     = back_q;
    idx_n      = idx_q;
    bcnt_n     = bcnt_q;
    scnt_n     = scnt_q;
    done_n     = done_q;
    err_n      = err_q;
    trk_clear  = 1'b0;
    trk_sample = 1'b0;
    if (start) begin
      ratio_n   = ratio_e'(ratio_sel);
      err_n     = 1'b0;
      back_n    = 1'b0;
      idx_n     = '0;
      trk_clear = 1'b1;
      done_n    = bypass;
      state_n   = bypass ? ST_IDLE : ST_REQ;
    end else if (wdog_exp) begin
      err_n   = (ratio_q != RATIO_X3P5);
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_REQ:  state_n = ST_ACK;
        ST_ACK: if (step_ack) begin
          scnt_n  = '0;
          state_n = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (scnt_q == settle_cycles) state_n = ST_EVAL;
          else                         scnt_n  = scnt_q + 1'b1;
        end
        ST_EVAL: begin
          if (!back_q) begin
            trk_sample = 1'b1;
            if (idx_q == LAST_IDX) state_n = ST_PICK;
            else begin
              idx_n   = idx_q + 1'b1;
              state_n = ST_REQ;
            end
          end else if (bcnt_q == IDX_W'(1)) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            bcnt_n  = bcnt_q - 1'b1;
            state_n = ST_REQ;
          end
        end
        ST_PICK: begin
          if (best_len == '0) begin
            err_n   = (ratio_q != RATIO_X3P5);
            state_n = ST_IDLE;
          end else if (back_steps == '0) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            back_n  = 1'b1;
            bcnt_n  = back_steps[IDX_W-1:0];
            state_n = ST_REQ;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      ratio_q <= RATIO_X2;
      back_q  <= 1'b0;
      idx_q   <= '0;
      bcnt_q  <= '0;
      scnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ratio_q <= ratio_n;
      back_q  <= back_n;
      idx_q   <= idx_n;
      bcnt_q  <= bcnt_n;
      scnt_q  <= scnt_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign step_req = (state_q == ST_REQ);
  assign step_dir = !back_q;
  assign done     = done_q;
  assign error    = err_q;

  // R4: a step request lasts one cycle
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    step_req |=> !step_req);
  // R10: outcome flags are exclusive
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(done && error));
  // R8: fractional ratio never reports an error
  p_frac_no_err_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ratio_q == RATIO_X3P5) |-> !error);
  // R6: done holds until a start
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !start) |=> done);
  // R6: error holds until a start
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (error && !start) |=> error);
endmodule

// File: tb/test_ptrain_ctrl.sv
module test_ptrain_ctrl;
  localparam int N = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic       rate_ok = 1'b1;
  logic       start = 1'b0;
  logic [7:0] settle_cycles = 8'd3;
  logic [7:0] wdog_limit = 8'd20;
  logic       io_clk_tgl = 1'b0;
  logic       step_ack = 1'b0;
  logic       eye_pass = 1'b0;
  logic       step_req, step_dir, done, error;

  logic [N-1:0] mask = '0;
  logic         io_alive = 1'b1;
  int           pos = 0, ups = 0, downs = 0, pll_cnt = 0;
  logic         pll_dir = 1'b1;
  int           n_chk = 0, n_fail = 0;
  int           cyc = 0;
  logic         wd_hit = 1'b0;

  always #5 clk = ~clk;

  ptrain_ctrl i_ptrain_ctrl (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .rate_ok(rate_ok),
    .start(start), .settle_cycles(settle_cycles), .wdog_limit(wdog_limit),
    .io_clk_tgl(io_clk_tgl), .step_ack(step_ack), .eye_pass(eye_pass),
    .step_req(step_req), .step_dir(step_dir), .done(done), .error(error)
  );

  // PLL and eye monitor model
  initial forever begin
    @(posedge clk); #1;
    step_ack = 1'b0;
    if (pll_cnt > 0) begin
      pll_cnt--;
      if (pll_cnt == 0) begin
        step_ack = 1'b1;
        if (pll_dir) begin pos++; ups++; end
        else         begin pos--; downs++; end
      end
    end
    if (step_req) begin
      pll_cnt = 2;
      pll_dir = step_dir;
    end
    eye_pass = (pos >= 1 && pos <= N) ? mask[pos-1] : 1'b0;
  end

  // high-speed domain activity toggle
  initial forever begin
    repeat (3) @(posedge clk);
    #1;
    if (io_alive) io_clk_tgl = ~io_clk_tgl;
  end

  // watchdog on the bench
  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] r, input logic rate);
    @(negedge clk);
    pos = 0; ups = 0; downs = 0;
    ratio_sel = r; rate_ok = rate; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input int max);
    for (int i = 0; i < max; i++) begin
      if (done || error || wd_hit) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(!done && !error && !step_req, "R1 reset", {done, error, step_req}, 0);
  endtask

  task automatic t_bypass_x5();
    kick(2'd3, 1'b1);
    repeat (4) @(negedge clk);
    chk(done && !error, "R2 x5 done", {done, error}, 2);
    chk(ups + downs == 0 && pll_cnt == 0, "R2 no step", ups + downs, 0);
  endtask

  task automatic t_bypass_rate();
    kick(2'd0, 1'b0);
    repeat (4) @(negedge clk);
    chk(done && !error, "R3 low rate done", {done, error}, 2);
    chk(ups + downs == 0, "R3 no step", ups + downs, 0);
  endtask

  task automatic t_sweep(input logic [1:0] r, input logic [N-1:0] m, input int exp_pos, input string tag);
    mask = m;
    kick(r, 1'b1);
    chk(!done && !error, "R6 start clears", {done, error}, 0);
    wait_end(2000);
    chk(done && !error, {tag, " done"}, {done, error}, 2);
    chk(ups == N, "R4 up steps", ups, N);
    chk(pos == exp_pos, {tag, " final offset"}, pos, exp_pos);
    repeat (20) @(negedge clk);
    chk(done && !error, "R6 done sticky", {done, error}, 2);
  endtask

  task automatic t_settle();
    int gap;
    mask = '1;
    kick(2'd2, 1'b1);
    gap = 0;
    while (!step_ack) @(negedge clk);
    while (!step_req) begin gap++; @(negedge clk); end
    // ack seen at cycle 0, settle 4 cycles, eval 1, then request
    chk(gap == int'(settle_cycles) + 3, "R4 settle gap", gap, int'(settle_cycles) + 3);
    wait_end(2000);
  endtask

  task automatic t_nopass(input logic [1:0] r);
    mask = '0;
    kick(r, 1'b1);
    wait_end(2000);
    if (r == 2'd1) begin
      repeat (50) @(negedge clk);
      chk(!done && !error, "R8 frac no pass", {done, error}, 0);
      chk(ups == N && downs == 0, "R8 sweep stops", ups, N);
    end else begin
      chk(error && !done, "R7 no pass error", {done, error}, 1);
      chk(downs == 0, "R7 no return", downs, 0);
    end
  endtask

  task automatic t_interrupt(input logic [1:0] r);
    int snap;
    mask = '1;
    kick(r, 1'b1);
    repeat (30) @(negedge clk);
    io_alive = 1'b0;
    repeat (60) @(negedge clk);
    snap = ups + downs;
    repeat (40) @(negedge clk);
    if (r == 2'd1) begin
      chk(!done && !error, "R8 frac interrupt", {done, error}, 0);
      chk(ups + downs == snap, "R8 stepping stopped", ups + downs, snap);
    end else begin
      chk(error && !done, "R9 interrupt error", {done, error}, 1);
      chk(ups + downs == snap, "R9 stepping stopped", ups + downs, snap);
    end
    io_alive = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bypass_x5();
    t_bypass_rate();
    // R5 single window 10..17, centre 13
    t_sweep(2'd0, 32'h0003_FC00, 14, "R5 single");
    // R5 windows 3..5 and 20..27, centre 23
    t_sweep(2'd2, 32'h0FF0_0038, 24, "R5 longest");
    // R5 tie 2..4 vs 10..12, first wins, centre 3
    t_sweep(2'd1, 32'h0000_1C1C, 4, "R5 tie");
    // R5 pass only at last position, no return
    t_sweep(2'd0, 32'h8000_0000, 32, "R5 last");
    chk(downs == 0, "R5 no down step", downs, 0);
    t_settle();
    t_nopass(2'd0);
    t_nopass(2'd1);
    t_interrupt(2'd2);
    t_interrupt(2'd1);
    if (wd_hit) chk(1'b0, "watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (wd_hit);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule